// File: doc/BRIEF.md
# Branch and Jump Target Address Calculator

This block works out the byte target of a control-transfer operation. It handles four operation kinds. Two are PC-relative: one adds an immediate or constant offset, the other adds a register plus an immediate. Two are absolute: one takes an immediate or constant, the other takes a register plus an immediate. The register value and the constant-bank word are fetched elsewhere and arrive as plain 32-bit operands, together with the next-instruction PC and the raw immediate field.

The three addends are widened to 35 signed bits and summed, so no carry is ever lost. The result must land in the 0 to 2^32-1 byte window, and it must be word aligned. A clean result updates the 32-bit target and a 40-bit virtual address, which is the program base plus the zero-extended target. A faulty result leaves both outputs as they were and raises the matching error flags for the one cycle in which the result is valid.

Top module: `br_target_calc`

## Requirements
- R1: One cycle after `req_i` is high, `vld_o` is high for exactly one cycle, and `vld_o` is low after any cycle without a request. After reset `vld_o`, `target_o`, `vaddr_o`, `range_err_o` and `align_err_o` are all 0.
- R2: With `kind_i`=2'b00 (relative, immediate form) and `use_const_i`=0, the target is `npc_i` plus the sign-extended `imm_i[23:0]`. Bits `imm_i[31:24]` have no effect.
- R3: With `kind_i`=2'b00 and `use_const_i`=1, the target is `npc_i` plus `const_i` read as a signed 32-bit value.
- R4: With `kind_i`=2'b10 (absolute, immediate form) and `use_const_i`=0, the target is `imm_i` read as an unsigned 32-bit value.
- R5: With `kind_i`=2'b10 and `use_const_i`=1, the target is `const_i` read as an unsigned 32-bit value.
- R6: With `kind_i`=2'b01 (relative, register form), the target is `npc_i` + signed `reg_i` + sign-extended `imm_i[23:0]`. `use_const_i` is ignored.
- R7: With `kind_i`=2'b11 (absolute, register form), the target is unsigned `reg_i` + signed 32-bit `imm_i`. The immediate stays signed even when `reg_i` is 0, and `use_const_i` is ignored.
- R8: The sum is formed without truncation. `range_err_o` is raised with `vld_o` when the sum is below 0 or above 2^32-1.
- R9: `align_err_o` is raised with `vld_o` in two cases: the final sum has a nonzero bit 0 or bit 1, or an immediate-form request (`kind_i[0]`=0, `use_const_i`=0) has a nonzero `imm_i[1:0]`.
- R10: When either error flag is raised, `target_o` and `vaddr_o` keep their previous values. The error flags are 0 whenever `vld_o` is 0.
- R11: On a clean result, `vaddr_o` equals `prog_base_i` from the request cycle plus the zero-extended target, taken modulo 2^40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, one calculation per cycle |
| kind_i | input | 2 | Operation kind: 00 rel-imm, 01 rel-reg, 10 abs-imm, 11 abs-reg |
| use_const_i | input | 1 | For immediate kinds, take the constant operand in place of the immediate |
| npc_i | input | 32 | Byte address of the next instruction |
| reg_i | input | 32 | Register operand |
| const_i | input | 32 | Constant-bank operand |
| imm_i | input | 32 | Immediate field |
| prog_base_i | input | 40 | Program base virtual address |
| vld_o | output | 1 | Result valid, one cycle after the request |
| target_o | output | 32 | Byte target within the program window |
| vaddr_o | output | 40 | Program base plus target |
| range_err_o | output | 1 | Sum fell outside 0..2^32-1 |
| align_err_o | output | 1 | Misaligned immediate or target |

## Verification
The hardest case to reach is a sum that crosses the window edge only because of the third addend. Examples are a relative-register sum in which the PC and the register together fit but the immediate carries the total past 2^32, and a zero register with a negative immediate. A 32-bit adder would wrap silently in both. Directed items place the operands a few bytes either side of 0 and 2^32. A bounded random phase then draws operands near those edges, and it interleaves faulty items with clean ones so that the hold behaviour is seen against a target that has just changed.

// File: rtl/br_calc_pkg.sv
`timescale 1ns/1ps
package br_calc_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned VA_W    = 40;
  localparam int unsigned IMM_S_W = 24;
  localparam int unsigned ALIGN_W = 2;
  localparam int unsigned SUM_W   = ADDR_W + 3;

  typedef enum logic [1:0] {
    K_REL_IMM = 2'b00,
    K_REL_REG = 2'b01,
    K_ABS_IMM = 2'b10,
    K_ABS_REG = 2'b11
  } br_kind_e;
endpackage

// File: rtl/br_operand_sel.sv
`timescale 1ns/1ps
module br_operand_sel
  import br_calc_pkg::*;
#(
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned IW  = IMM_S_W,
  parameter int unsigned LW  = ALIGN_W,
  parameter int unsigned SW  = SUM_W
) (
  input  br_kind_e              kind_i,
  input  logic                  use_const_i,
  input  logic [AW-1:0]         npc_i,
  input  logic [AW-1:0]         reg_i,
  input  logic [AW-1:0]         const_i,
  input  logic [AW-1:0]         imm_i,
  output logic signed [SW-1:0]  add_a_o,
  output logic signed [SW-1:0]  add_b_o,
  output logic signed [SW-1:0]  add_c_o,
  output logic                  imm_lsb_bad_o
);
  localparam int unsigned XW = SW - AW;
  localparam int unsigned SX = SW - IW;

  logic signed [SW-1:0] npc_z, reg_z, reg_s, cst_z, cst_s, imm_z, imm_s, imm_n;

  // widen each operand in both readings
  assign npc_z = {{XW{1'b0}}, npc_i};
  assign reg_z = {{XW{1'b0}}, reg_i};
  assign reg_s = {{XW{reg_i[AW-1]}}, reg_i};
  assign cst_z = {{XW{1'b0}}, const_i};
  assign cst_s = {{XW{const_i[AW-1]}}, const_i};
  assign imm_z = {{XW{1'b0}}, imm_i};
  assign imm_s = {{XW{imm_i[AW-1]}}, imm_i};
  assign imm_n = {{SX{imm_i[IW-1]}}, imm_i[IW-1:0]};

  always_comb begin
    add_a_o = '0;
    add_b_o = '0;
    add_c_o = '0;
    unique case (kind_i)
      K_REL_IMM: begin
        add_a_o = npc_z;
        add_b_o = use_const_i ? cst_s : imm_n;
      end
      K_REL_REG: begin
        add_a_o = npc_z;
        add_b_o = reg_s;
        add_c_o = imm_n;
      end
      K_ABS_IMM: begin
        add_b_o = use_const_i ? cst_z : imm_z;
      end
      K_ABS_REG: begin
        add_b_o = reg_z;
        add_c_o = imm_s;
      end
      default: ;
    endcase
  end

  // immediate encodings carry a word-aligned byte offset
  assign imm_lsb_bad_o = !kind_i[0] && !use_const_i && (|imm_i[LW-1:0]);
endmodule

// File: rtl/br_sum_check.sv
`timescale 1ns/1ps
module br_sum_check
  import br_calc_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned LW = ALIGN_W,
  parameter int unsigned SW = SUM_W
) (
  input  logic signed [SW-1:0] add_a_i,
  input  logic signed [SW-1:0] add_b_i,
  input  logic signed [SW-1:0] add_c_i,
  input  logic                 imm_lsb_bad_i,
  output logic [AW-1:0]        target_o,
  output logic                 range_bad_o,
  output logic                 align_bad_o
);
  logic signed [SW-1:0] sum;

  assign sum         = add_a_i + add_b_i + add_c_i;
  // any bit above the window (incl. sign) means out of 0..2^AW-1
  assign range_bad_o = |sum[SW-1:AW];
  assign align_bad_o = imm_lsb_bad_i || (|sum[LW-1:0]);
  assign target_o    = sum[AW-1:0];
endmodule

// File: rtl/br_result_reg.sv
`timescale 1ns/1ps
module br_result_reg
  import br_calc_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned VW = VA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] target_i,
  input  logic [VW-1:0] base_i,
  input  logic          range_bad_i,
  input  logic          align_bad_i,
  output logic          vld_o,
  output logic [AW-1:0] target_o,
  output logic [VW-1:0] vaddr_o,
  output logic          range_err_o,
  output logic          align_err_o
);
  logic          ok;
  logic [VW-1:0] va_next;

  assign ok      = !range_bad_i && !align_bad_i;
  assign va_next = base_i + {{(VW-AW){1'b0}}, target_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o       <= 1'b0;
      target_o    <= '0;
      vaddr_o     <= '0;
      range_err_o <= 1'b0;
      align_err_o <= 1'b0;
    end else begin
      vld_o       <= req_i;
      range_err_o <= req_i && range_bad_i;
      align_err_o <= req_i && align_bad_i;
      if (req_i && ok) begin
        target_o <= target_i;
        vaddr_o  <= va_next;
      end
    end
  end
endmodule

// File: rtl/br_target_calc.sv
`timescale 1ns/1ps
module br_target_calc
  import br_calc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        kind_i,
  input  logic              use_const_i,
  input  logic [ADDR_W-1:0] npc_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [ADDR_W-1:0] const_i,
  input  logic [ADDR_W-1:0] imm_i,
  input  logic [VA_W-1:0]   prog_base_i,
  output logic              vld_o,
  output logic [ADDR_W-1:0] target_o,
  output logic [VA_W-1:0]   vaddr_o,
  output logic              range_err_o,
  output logic              align_err_o
);
  logic signed [SUM_W-1:0] add_a, add_b, add_c;
  logic                    imm_lsb_bad;
  logic [ADDR_W-1:0]       sum_tgt;
  logic                    range_bad, align_bad;

  br_operand_sel #(
    .AW(ADDR_W), .IW(IMM_S_W), .LW(ALIGN_W), .SW(SUM_W)
  ) u_opsel (
    .kind_i       (br_kind_e'(kind_i)),
    .use_const_i  (use_const_i),
    .npc_i        (npc_i),
    .reg_i        (reg_i),
    .const_i      (const_i),
    .imm_i        (imm_i),
    .add_a_o      (add_a),
    .add_b_o      (add_b),
    .add_c_o      (add_c),
    .imm_lsb_bad_o(imm_lsb_bad)
  );

  br_sum_check #(
    .AW(ADDR_W), .LW(ALIGN_W), .SW(SUM_W)
  ) u_sum (
    .add_a_i      (add_a),
    .add_b_i      (add_b),
    .add_c_i      (add_c),
    .imm_lsb_bad_i(imm_lsb_bad),
    .target_o     (sum_tgt),
    .range_bad_o  (range_bad),
    .align_bad_o  (align_bad)
  );

  br_result_reg #(
    .AW(ADDR_W), .VW(VA_W)
  ) u_res (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .target_i   (sum_tgt),
    .base_i     (prog_base_i),
    .range_bad_i(range_bad),
    .align_bad_i(align_bad),
    .vld_o      (vld_o),
    .target_o   (target_o),
    .vaddr_o    (vaddr_o),
    .range_err_o(range_err_o),
    .align_err_o(align_err_o)
  );
endmodule

// File: rtl/br_target_calc_chk.sv
`timescale 1ns/1ps
module br_target_calc_chk
  import br_calc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [1:0]        kind_i,
  input logic              use_const_i,
  input logic [ADDR_W-1:0] imm_i,
  input logic [VA_W-1:0]   prog_base_i,
  input logic              vld_o,
  input logic [ADDR_W-1:0] target_o,
  input logic [VA_W-1:0]   vaddr_o,
  input logic              range_err_o,
  input logic              align_err_o
);
  AST_VLD_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> vld_o); // R1
  AST_NO_VLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !vld_o); // R1
  AST_ABS_IMM_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && kind_i == 2'b10 && !use_const_i && imm_i[1:0] == 2'b00)
      |=> (!range_err_o && !align_err_o && target_o == $past(imm_i))); // R4
  AST_CLEAN_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !align_err_o && !range_err_o) |-> target_o[1:0] == 2'b00); // R9
  AST_HOLD_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && (range_err_o || align_err_o)) |-> ($stable(target_o) && $stable(vaddr_o))); // R10
  AST_FLAGS_ONLY_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> (!range_err_o && !align_err_o)); // R10
  AST_VADDR_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i ##1 (vld_o && !range_err_o && !align_err_o))
      |-> vaddr_o == $past(prog_base_i) + {{(VA_W-ADDR_W){1'b0}}, target_o}); // R11
endmodule

bind br_target_calc br_target_calc_chk chk_i (.*);

// File: tb/br_target_calc_tb_top.sv
`timescale 1ns/1ps
module br_target_calc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  kind = 2'b00;
  logic        use_const = 1'b0;
  logic [31:0] npc = '0, rg = '0, cst = '0, imm = '0;
  logic [39:0] base = '0;
  logic        vld;
  logic [31:0] tgt;
  logic [39:0] va;
  logic        rerr, aerr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  br_target_calc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .kind_i(kind),
    .use_const_i(use_const), .npc_i(npc), .reg_i(rg), .const_i(cst),
    .imm_i(imm), .prog_base_i(base), .vld_o(vld), .target_o(tgt),
    .vaddr_o(va), .range_err_o(rerr), .align_err_o(aerr)
  );

  typedef struct {
    logic [31:0] t;
    logic [39:0] v;
    logic        re;
    logic        ae;
    string       rq;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] m_tgt = '0;
  logic [39:0] m_va = '0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  function automatic longint sx24(input logic [31:0] v);
    logic signed [23:0] t;
    t = v[23:0];
    return longint'(t);
  endfunction

  function automatic longint sx32(input logic [31:0] v);
    logic signed [31:0] t;
    t = v;
    return longint'(t);
  endfunction

  task automatic send(input logic [1:0] k, input logic uc, input logic [31:0] p,
                      input logic [31:0] r, input logic [31:0] c, input logic [31:0] i,
                      input logic [39:0] b, input string rq);
    longint s;
    exp_t   e;
    @(negedge clk);
    req = 1'b1; kind = k; use_const = uc; npc = p; rg = r; cst = c; imm = i; base = b;
    case (k)
      2'b00:   s = longint'(p) + (uc ? sx32(c) : sx24(i));
      2'b01:   s = longint'(p) + sx32(r) + sx24(i);
      2'b10:   s = uc ? longint'(c) : longint'(i);
      default: s = longint'(r) + sx32(i);
    endcase
    e.re = (s < 0) || (s > 64'sh0FFFF_FFFF);
    e.ae = (s[1:0] != 2'b00) || (!k[0] && !uc && i[1:0] != 2'b00);
    if (!e.re && !e.ae) begin
      m_tgt = s[31:0];
      m_va  = b + {8'h00, s[31:0]};
    end
    e.t  = m_tgt;
    e.v  = m_va;
    e.rq = rq;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      req = 1'b0;
    end
  endtask

  // monitor: compare every valid result against the queue head
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (vld) begin
          if (sb.size() == 0) begin
            chk(1'b0, "R1", "unexpected vld", 1, 0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            chk(tgt == e.t, e.rq, "target", tgt, e.t);
            chk(va == e.v, e.rq, "vaddr R11", va, e.v);
            chk(rerr == e.re, e.rq, "range_err R8", rerr, e.re);
            chk(aerr == e.ae, e.rq, "align_err R9", aerr, e.ae);
          end
        end else begin
          chk(!rerr && !aerr, "R10", "flags without vld", {rerr, aerr}, 0);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!vld && tgt == 0 && va == 0 && !rerr && !aerr, "R1", "reset state",
        {vld, rerr, aerr, tgt}, 0);
    rst_n = 1'b1;
    idle(2);

    send(2'b00, 0, 32'h1000, 0, 0, 32'h0000_0028, 40'h10_0000_0000, "R2");
    send(2'b00, 0, 32'h1000, 0, 0, 32'hAB_FFFFF0, 40'h10_0000_0000, "R2");
    send(2'b00, 0, 32'h0000_0010, 0, 0, 32'h00FF_FFE0, 40'h0, "R8");
    send(2'b00, 0, 32'h1000, 0, 0, 32'h0000_0006, 40'h0, "R9");
    send(2'b00, 1, 32'h2000, 0, 32'hFFFF_F000, 32'h3, 40'h0, "R3");
    send(2'b00, 1, 32'hFFFF_FF00, 0, 32'h0000_0200, 0, 40'h0, "R3");
    idle(1);
    send(2'b10, 0, 32'h5555_5555, 0, 0, 32'h0012_8000, 40'h01_0000_0000, "R4");
    send(2'b10, 0, 0, 0, 0, 32'h0000_1002, 40'h0, "R10");
    send(2'b10, 1, 0, 0, 32'h0000_CA80, 32'h3, 40'h02_0000_0000, "R5");
    send(2'b10, 1, 0, 0, 32'h0000_0013, 0, 40'h0, "R9");
    send(2'b01, 1, 32'h4000, 32'hFFFF_FF00, 0, 32'h0000_0128, 40'h0, "R6");
    send(2'b01, 0, 32'hFFFF_FFF0, 32'h0000_000C, 0, 0, 40'hFF_0000_0000, "R6");
    send(2'b01, 0, 32'hFFFF_FFF0, 32'h0000_000C, 0, 32'h0000_0004, 40'h0, "R8");
    send(2'b11, 0, 0, 32'h0, 0, 32'hFFFF_FFFC, 40'h0, "R7");
    send(2'b11, 1, 0, 32'h0000_0100, 0, 32'hFFFF_FFF0, 40'hFF_FFFF_FFFF, "R7");
    send(2'b11, 0, 0, 32'hFFFF_FFF0, 0, 32'h0000_0010, 40'h0, "R8");
    send(2'b11, 0, 0, 32'h0000_0005, 0, 32'h0000_0123, 40'h0, "R7");
    idle(3);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] p, r, c, i;
      logic [1:0]  k;
      k = 2'($urandom_range(0, 3));
      p = ($urandom_range(0, 1) != 0) ? (32'hFFFF_FF00 | 32'($urandom_range(0, 255)))
                                      : 32'($urandom_range(0, 512));
      r = ($urandom_range(0, 1) != 0) ? 32'($urandom) : (32'hFFFF_FF00 | 32'($urandom_range(0, 255)));
      c = 32'($urandom);
      i = ($urandom_range(0, 3) == 0) ? 32'($urandom) : (32'($urandom_range(0, 1023)) & 32'hFFFF_FFFC);
      send(k, 1'($urandom_range(0, 1)), p, r, c, i, {8'($urandom), 32'($urandom)},
           (k == 2'b00) ? "R2" : (k == 2'b01) ? "R6" : (k == 2'b10) ? "R4" : "R7");
      if ($urandom_range(0, 4) == 0) idle(1);
    end
    idle(4);
    chk(sb.size() == 0, "R1", "pending results", sb.size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule